// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block holds the microprogram counter of a microcoded controller and works out, every clock, which control-store word comes next. The current microinstruction supplies a 4-bit condition selector and a 6-bit jump target. The datapath and memory supply five status flags: interrupt pending, memory busy, ALU result zero, ALU result negative, and current instruction is a load. The instruction register supplies a 6-bit main opcode and a 6-bit function opcode.

The next address can be one of three things. It can be the counter plus one. It can be the jump target, when the selected status test is true. It can be an entry point read from one of three opcode-indexed dispatch lookups. The first lookup also diverts to the interrupt handler when an interrupt is waiting. Any opcode that a lookup does not list lands on the trap handler. A microinstruction that waits on memory and jumps to its own address holds the counter until memory is done. The control store itself and the datapath lie outside this block.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low, `upc` is 0. Reset is asynchronous and active low.
- R2: For condition code 0, `upc` advances by one on each rising clock edge. It wraps from 63 to 0.
- R3: For condition code 1, the next `upc` is `jump_addr`.
- R4: Codes 2 to 6 test one flag each: 2 tests `irq_pending`, 3 tests `mem_busy`, 4 tests `alu_zero`, 5 tests `alu_neg` and 6 tests `instr_is_load`. If the flag is 1 the next `upc` is `jump_addr`, otherwise it is `upc`+1.
- R5: Code 10 jumps to `jump_addr` when `alu_zero` is 0. Otherwise it steps to `upc`+1.
- R6: Codes 11 to 15 step to `upc`+1, whatever the flags are.
- R7: Code 7 dispatches on `main_op` when `irq_pending` is 0. The entry points are:
  - 0x00 goes to 23.
  - 0x08, 0x0A, 0x0C to 0x0F, 0x14, 0x16 to 0x1D go to 24.
  - 0x20, 0x21, 0x23, 0x24, 0x25, 0x28, 0x29, 0x2B go to 5.
  - 0x02 goes to 54, 0x12 to 55, 0x03 to 56, 0x13 to 58.
  - 0x04 goes to 50 and 0x05 to 52.
  - 0x11 goes to 60.
- R8: Code 7 with `irq_pending` at 1 goes to 2, whatever the opcode.
- R9: Code 8 dispatches on `func_op` with these entry points:
  - 0x20 goes to 25, 0x22 to 26, 0x24 to 27, 0x25 to 28, 0x26 to 29.
  - 0x04 goes to 30, 0x06 to 31, 0x07 to 32, 0x0F to 33.
  - 0x28 goes to 35, 0x29 to 37, 0x2A to 39, 0x2D to 41, 0x2B to 43, 0x2C to 45.
  - 0x30 goes to 11, 0x34 to 13, 0x31 to 15, 0x35 to 17, 0x33 to 19.
- R10: Code 9 dispatches on `main_op` with these entry points:
  - 0x08 goes to 25, 0x0A to 26, 0x0C to 27, 0x0D to 28, 0x0E to 29.
  - 0x14 goes to 30, 0x16 to 31, 0x17 to 32, 0x0F to 33.
  - 0x18 goes to 35, 0x19 to 37, 0x1A to 39, 0x1D to 41, 0x1B to 43, 0x1C to 45.
  - 0x20 goes to 11, 0x24 to 13, 0x21 to 15, 0x25 to 17, 0x23 to 19.
- R11: Any opcode not listed for the active lookup (R7, R9 or R10) sends `upc` to 60.
- R12: Code 3 with `mem_busy` at 1 and `jump_addr` equal to `upc` holds `upc` for as long as `mem_busy` stays 1. The cycle after `mem_busy` drops, `upc` steps by one.
- R13: Codes 8 and 9 ignore `irq_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_code | input | 4 | Condition selector of the current microinstruction |
| jump_addr | input | 6 | Jump target of the current microinstruction |
| irq_pending | input | 1 | Interrupt waiting between instructions |
| mem_busy | input | 1 | Memory access not yet complete |
| alu_zero | input | 1 | ALU result is zero |
| alu_neg | input | 1 | ALU result is negative |
| instr_is_load | input | 1 | Current instruction is a load |
| main_op | input | 6 | Main opcode field of the instruction register |
| func_op | input | 6 | Function opcode field of the instruction register |
| upc | output | 6 | Microprogram counter |

## Verification
Two functions can act in the same cycle: the main-opcode dispatch and the interrupt divert. Both are driven by code 7. The bench raises `irq_pending` together with code 7 for listed opcodes, for unlisted ones and for the trap opcode. It expects entry 2 every time and never the opcode's own target. It then raises `irq_pending` with codes 8 and 9 and expects the normal table target. This shows that the divert is tied to the first lookup alone. A second overlap is the memory-wait self-jump against the increment. Holding `mem_busy` high over several cycles must freeze `upc`. Releasing it must give exactly one step.

// File: rtl/useq_pkg.sv
package useq_pkg;

   // condition selector codes
   localparam int CC_SEQ     = 0;
   localparam int CC_ALWAYS  = 1;
   localparam int CC_IRQ     = 2;
   localparam int CC_MEMWAIT = 3;
   localparam int CC_ZERO    = 4;
   localparam int CC_NEG     = 5;
   localparam int CC_LOAD    = 6;
   localparam int CC_DISP_A  = 7;
   localparam int CC_DISP_B  = 8;
   localparam int CC_DISP_C  = 9;
   localparam int CC_NONZERO = 10;

   // entry points (6-bit microaddresses)
   localparam logic [5:0] UA_MEM   = 6'd5;
   localparam logic [5:0] UA_RREG  = 6'd23;
   localparam logic [5:0] UA_RIMM  = 6'd24;
   localparam logic [5:0] UA_BEQZ  = 6'd50;
   localparam logic [5:0] UA_BNEZ  = 6'd52;
   localparam logic [5:0] UA_JMP   = 6'd54;
   localparam logic [5:0] UA_JREG  = 6'd55;
   localparam logic [5:0] UA_JLNK  = 6'd56;
   localparam logic [5:0] UA_JLNKR = 6'd58;
   localparam logic [5:0] UA_TRAP  = 6'd60;

   typedef enum logic [1:0] {
      DISP_NONE,
      DISP_A,
      DISP_B,
      DISP_C
   } disp_sel_e;

   typedef enum logic [4:0] {
      K_NONE, K_LB, K_LBU, K_LH, K_LHU, K_LW,
      K_ADD, K_SUB, K_AND, K_OR, K_XOR,
      K_SLL, K_SRL, K_SRA, K_LHI,
      K_SEQ, K_SNE, K_SLT, K_SGE, K_SGT, K_SLE
   } op_kind_e;

   typedef struct packed {
      logic irq;
      logic mem_busy;
      logic zero;
      logic neg;
      logic is_load;
   } status_t;

   // first lookup: main opcode to routine entry
   function automatic logic [5:0] main_entry(input logic [5:0] op);
      logic [5:0] e;
      case (op)
         6'h00:                       e = UA_RREG;
         6'h08, 6'h0A, 6'h0C, 6'h0D,
         6'h0E, 6'h0F, 6'h14, 6'h16,
         6'h17, 6'h18, 6'h19, 6'h1A,
         6'h1B, 6'h1C, 6'h1D:         e = UA_RIMM;
         6'h20, 6'h21, 6'h23, 6'h24,
         6'h25, 6'h28, 6'h29, 6'h2B:  e = UA_MEM;
         6'h02:                       e = UA_JMP;
         6'h12:                       e = UA_JREG;
         6'h03:                       e = UA_JLNK;
         6'h13:                       e = UA_JLNKR;
         6'h04:                       e = UA_BEQZ;
         6'h05:                       e = UA_BNEZ;
         default:                     e = UA_TRAP;
      endcase
      return e;
   endfunction

   // operation kind from the main opcode (third lookup)
   function automatic op_kind_e main_kind(input logic [5:0] op);
      op_kind_e k;
      case (op)
         6'h20: k = K_LB;
         6'h24: k = K_LBU;
         6'h21: k = K_LH;
         6'h25: k = K_LHU;
         6'h23: k = K_LW;
         6'h08: k = K_ADD;
         6'h0A: k = K_SUB;
         6'h0C: k = K_AND;
         6'h0D: k = K_OR;
         6'h0E: k = K_XOR;
         6'h14: k = K_SLL;
         6'h16: k = K_SRL;
         6'h17: k = K_SRA;
         6'h0F: k = K_LHI;
         6'h18: k = K_SEQ;
         6'h19: k = K_SNE;
         6'h1A: k = K_SLT;
         6'h1D: k = K_SGE;
         6'h1B: k = K_SGT;
         6'h1C: k = K_SLE;
         default: k = K_NONE;
      endcase
      return k;
   endfunction

   // operation kind from the function opcode (second lookup)
   function automatic op_kind_e func_kind(input logic [5:0] op);
      op_kind_e k;
      case (op)
         6'h30: k = K_LB;
         6'h34: k = K_LBU;
         6'h31: k = K_LH;
         6'h35: k = K_LHU;
         6'h33: k = K_LW;
         6'h20: k = K_ADD;
         6'h22: k = K_SUB;
         6'h24: k = K_AND;
         6'h25: k = K_OR;
         6'h26: k = K_XOR;
         6'h04: k = K_SLL;
         6'h06: k = K_SRL;
         6'h07: k = K_SRA;
         6'h0F: k = K_LHI;
         6'h28: k = K_SEQ;
         6'h29: k = K_SNE;
         6'h2A: k = K_SLT;
         6'h2D: k = K_SGE;
         6'h2B: k = K_SGT;
         6'h2C: k = K_SLE;
         default: k = K_NONE;
      endcase
      return k;
   endfunction

   // shared kind-to-entry map for the second and third lookups
   function automatic logic [5:0] kind_entry(input op_kind_e k);
      logic [5:0] e;
      case (k)
         K_LB:    e = 6'd11;
         K_LBU:   e = 6'd13;
         K_LH:    e = 6'd15;
         K_LHU:   e = 6'd17;
         K_LW:    e = 6'd19;
         K_ADD:   e = 6'd25;
         K_SUB:   e = 6'd26;
         K_AND:   e = 6'd27;
         K_OR:    e = 6'd28;
         K_XOR:   e = 6'd29;
         K_SLL:   e = 6'd30;
         K_SRL:   e = 6'd31;
         K_SRA:   e = 6'd32;
         K_LHI:   e = 6'd33;
         K_SEQ:   e = 6'd35;
         K_SNE:   e = 6'd37;
         K_SLT:   e = 6'd39;
         K_SGE:   e = 6'd41;
         K_SGT:   e = 6'd43;
         K_SLE:   e = 6'd45;
         default: e = UA_TRAP;
      endcase
      return e;
   endfunction

endpackage

// File: rtl/useq_cond_eval.sv
module useq_cond_eval
   import useq_pkg::*;
#(
   parameter int COND_W = 4
) (
   input  logic [COND_W-1:0] cond_code,
   input  status_t           status,
   output logic              take_jump,
   output disp_sel_e         disp_sel
);

   always_comb begin
      take_jump = 1'b0;
      disp_sel  = DISP_NONE;
      if (cond_code == COND_W'(CC_ALWAYS))       take_jump = 1'b1;
      else if (cond_code == COND_W'(CC_IRQ))     take_jump = status.irq;
      else if (cond_code == COND_W'(CC_MEMWAIT)) take_jump = status.mem_busy;
      else if (cond_code == COND_W'(CC_ZERO))    take_jump = status.zero;
      else if (cond_code == COND_W'(CC_NEG))     take_jump = status.neg;
      else if (cond_code == COND_W'(CC_LOAD))    take_jump = status.is_load;
      else if (cond_code == COND_W'(CC_NONZERO)) take_jump = ~status.zero;
      else if (cond_code == COND_W'(CC_DISP_A))  disp_sel  = DISP_A;
      else if (cond_code == COND_W'(CC_DISP_B))  disp_sel  = DISP_B;
      else if (cond_code == COND_W'(CC_DISP_C))  disp_sel  = DISP_C;
   end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
   import useq_pkg::*;
#(
   parameter int UADDR_W      = 6,
   parameter int OP_W         = 6,
   parameter int IRQ_ENTRY    = 2,
   parameter bit SHARE_LOOKUP = 1'b1
) (
   input  disp_sel_e          disp_sel,
   input  logic [OP_W-1:0]    main_op,
   input  logic [OP_W-1:0]    func_op,
   input  logic               irq,
   output logic [UADDR_W-1:0] target
);

   localparam logic [UADDR_W-1:0] IRQ_UA = UADDR_W'(IRQ_ENTRY);

   logic [UADDR_W-1:0] first_tgt;
   logic [UADDR_W-1:0] alu_tgt;

   // first lookup, with interrupt divert
   always_comb begin
      if (irq) first_tgt = IRQ_UA;
      else     first_tgt = UADDR_W'(main_entry(main_op[5:0]));
   end

   generate
      if (SHARE_LOOKUP) begin : g_shared
         op_kind_e kind;
         always_comb begin
            if (disp_sel == DISP_B) kind = func_kind(func_op[5:0]);
            else                    kind = main_kind(main_op[5:0]);
            alu_tgt = UADDR_W'(kind_entry(kind));
         end
      end else begin : g_split
         logic [5:0] func_tgt;
         logic [5:0] main_tgt;
         always_comb begin
            func_tgt = kind_entry(func_kind(func_op[5:0]));
            main_tgt = kind_entry(main_kind(main_op[5:0]));
            alu_tgt  = (disp_sel == DISP_B) ? UADDR_W'(func_tgt)
                                            : UADDR_W'(main_tgt);
         end
      end
   endgenerate

   assign target = (disp_sel == DISP_A) ? first_tgt : alu_tgt;

endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel
   import useq_pkg::*;
#(
   parameter int UADDR_W = 6
) (
   input  logic [UADDR_W-1:0] cur_upc,
   input  logic [UADDR_W-1:0] jump_addr,
   input  logic [UADDR_W-1:0] disp_target,
   input  logic               take_jump,
   input  disp_sel_e          disp_sel,
   output logic [UADDR_W-1:0] next_upc
);

   logic [UADDR_W-1:0] incr;
   assign incr = cur_upc + UADDR_W'(1);

   always_comb begin
      if (disp_sel != DISP_NONE) next_upc = disp_target;
      else if (take_jump)        next_upc = jump_addr;
      else                       next_upc = incr;
   end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
   import useq_pkg::*;
#(
   parameter int UADDR_W      = 6,
   parameter int OP_W         = 6,
   parameter int COND_W       = 4,
   parameter int IRQ_ENTRY    = 2,
   parameter bit SHARE_LOOKUP = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [COND_W-1:0]  cond_code,
   input  logic [UADDR_W-1:0] jump_addr,
   input  logic               irq_pending,
   input  logic               mem_busy,
   input  logic               alu_zero,
   input  logic               alu_neg,
   input  logic               instr_is_load,
   input  logic [OP_W-1:0]    main_op,
   input  logic [OP_W-1:0]    func_op,
   output logic [UADDR_W-1:0] upc
);

   localparam int UA_SPAN = 1 << UADDR_W;

   generate
      if (UADDR_W < 6) begin : g_bad_uaddr
         $error("UADDR_W must hold entry point 60");
      end
      if (OP_W != 6) begin : g_bad_op
         $error("dispatch lookups are defined for 6-bit opcodes");
      end
      if (COND_W < 4) begin : g_bad_cond
         $error("COND_W must hold code 10");
      end
      if (IRQ_ENTRY >= UA_SPAN) begin : g_bad_irq
         $error("IRQ_ENTRY outside microaddress space");
      end
   endgenerate

   status_t            status;
   logic               take_jump;
   disp_sel_e          disp_sel;
   logic [UADDR_W-1:0] disp_target;
   logic [UADDR_W-1:0] next_upc;

   assign status = '{irq: irq_pending, mem_busy: mem_busy, zero: alu_zero,
                     neg: alu_neg, is_load: instr_is_load};

   useq_cond_eval #(.COND_W(COND_W)) u_cond (
      .cond_code (cond_code),
      .status    (status),
      .take_jump (take_jump),
      .disp_sel  (disp_sel)
   );

   useq_dispatch #(
      .UADDR_W      (UADDR_W),
      .OP_W         (OP_W),
      .IRQ_ENTRY    (IRQ_ENTRY),
      .SHARE_LOOKUP (SHARE_LOOKUP)
   ) u_disp (
      .disp_sel (disp_sel),
      .main_op  (main_op),
      .func_op  (func_op),
      .irq      (irq_pending),
      .target   (disp_target)
   );

   useq_next_sel #(.UADDR_W(UADDR_W)) u_next (
      .cur_upc     (upc),
      .jump_addr   (jump_addr),
      .disp_target (disp_target),
      .take_jump   (take_jump),
      .disp_sel    (disp_sel),
      .next_upc    (next_upc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc <= '0;
      else        upc <= next_upc;
   end

   // R2: plain sequencing advances by one with wrap
   assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_code == COND_W'(CC_SEQ)) |=> (upc == UADDR_W'($past(upc) + 1'b1)));

   // R3: unconditional jump
   assert_always_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_code == COND_W'(CC_ALWAYS)) |=> (upc == $past(jump_addr)));

   // R5: not-zero test
   assert_nonzero_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_code == COND_W'(CC_NONZERO) && !alu_zero) |=> (upc == $past(jump_addr)));

   // R8: interrupt divert on first lookup
   assert_irq_divert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_code == COND_W'(CC_DISP_A) && irq_pending) |=> (upc == UADDR_W'(IRQ_ENTRY)));

   // R12: memory wait holds the counter
   assert_mem_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_code == COND_W'(CC_MEMWAIT) && mem_busy && jump_addr == upc) |=> $stable(upc));

   // R13: third lookup ignores a pending interrupt
   assert_third_no_irq_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_code == COND_W'(CC_DISP_C) && irq_pending && main_op == OP_W'(6'h08))
      |=> (upc == UADDR_W'(25)));

endmodule

// File: tb/useq_sequencer_bench.sv
module useq_sequencer_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cond_code = 4'd1;
   logic [5:0] jump_addr = 6'd0;
   logic       irq_pending = 1'b0;
   logic       mem_busy = 1'b0;
   logic       alu_zero = 1'b0;
   logic       alu_neg = 1'b0;
   logic       instr_is_load = 1'b0;
   logic [5:0] main_op = 6'd0;
   logic [5:0] func_op = 6'd0;
   logic [5:0] upc;

   int n_checks = 0;
   int n_fail   = 0;
   logic [5:0] model_upc = 6'd0;
   logic [5:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   useq_sequencer u_useq_sequencer (
      .clk           (clk),
      .rst_n         (rst_n),
      .cond_code     (cond_code),
      .jump_addr     (jump_addr),
      .irq_pending   (irq_pending),
      .mem_busy      (mem_busy),
      .alu_zero      (alu_zero),
      .alu_neg       (alu_neg),
      .instr_is_load (instr_is_load),
      .main_op       (main_op),
      .func_op       (func_op),
      .upc           (upc)
   );

   // expected first-lookup entry (R7, R11)
   function automatic logic [5:0] ref_first(input logic [5:0] op);
      case (op)
         6'h00: return 6'd23;
         6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E, 6'h0F, 6'h14, 6'h16,
         6'h17, 6'h18, 6'h19, 6'h1A, 6'h1B, 6'h1C, 6'h1D: return 6'd24;
         6'h20, 6'h21, 6'h23, 6'h24, 6'h25, 6'h28, 6'h29, 6'h2B: return 6'd5;
         6'h02: return 6'd54;
         6'h12: return 6'd55;
         6'h03: return 6'd56;
         6'h13: return 6'd58;
         6'h04: return 6'd50;
         6'h05: return 6'd52;
         default: return 6'd60;
      endcase
   endfunction

   // expected second-lookup entry by function opcode (R9, R11)
   function automatic logic [5:0] ref_func(input logic [5:0] op);
      case (op)
         6'h20: return 6'd25;  6'h22: return 6'd26;  6'h24: return 6'd27;
         6'h25: return 6'd28;  6'h26: return 6'd29;  6'h04: return 6'd30;
         6'h06: return 6'd31;  6'h07: return 6'd32;  6'h0F: return 6'd33;
         6'h28: return 6'd35;  6'h29: return 6'd37;  6'h2A: return 6'd39;
         6'h2D: return 6'd41;  6'h2B: return 6'd43;  6'h2C: return 6'd45;
         6'h30: return 6'd11;  6'h34: return 6'd13;  6'h31: return 6'd15;
         6'h35: return 6'd17;  6'h33: return 6'd19;
         default: return 6'd60;
      endcase
   endfunction

   // expected third-lookup entry by main opcode (R10, R11)
   function automatic logic [5:0] ref_third(input logic [5:0] op);
      case (op)
         6'h08: return 6'd25;  6'h0A: return 6'd26;  6'h0C: return 6'd27;
         6'h0D: return 6'd28;  6'h0E: return 6'd29;  6'h14: return 6'd30;
         6'h16: return 6'd31;  6'h17: return 6'd32;  6'h0F: return 6'd33;
         6'h18: return 6'd35;  6'h19: return 6'd37;  6'h1A: return 6'd39;
         6'h1D: return 6'd41;  6'h1B: return 6'd43;  6'h1C: return 6'd45;
         6'h20: return 6'd11;  6'h24: return 6'd13;  6'h21: return 6'd15;
         6'h25: return 6'd17;  6'h23: return 6'd19;
         default: return 6'd60;
      endcase
   endfunction

   function automatic logic [5:0] ref_next(input logic [5:0] cur, input logic [3:0] cc,
                                           input logic [5:0] ja, input logic irq, busy,
                                           z, n, ld, input logic [5:0] mop, fop);
      logic [5:0] inc = cur + 6'd1;
      case (cc)
         4'd0:  return inc;
         4'd1:  return ja;
         4'd2:  return irq  ? ja : inc;
         4'd3:  return busy ? ja : inc;
         4'd4:  return z    ? ja : inc;
         4'd5:  return n    ? ja : inc;
         4'd6:  return ld   ? ja : inc;
         4'd7:  return irq  ? 6'd2 : ref_first(mop);
         4'd8:  return ref_func(fop);
         4'd9:  return ref_third(mop);
         4'd10: return !z   ? ja : inc;
         default: return inc;
      endcase
   endfunction

   // driver: applies one microinstruction and queues the expected counter
   task automatic step(input logic [3:0] cc, input logic [5:0] ja, input logic irq,
                       input logic busy, input logic z, input logic n, input logic ld,
                       input logic [5:0] mop, input logic [5:0] fop, input string tag);
      logic [5:0] e;
      @(negedge clk);
      cond_code = cc; jump_addr = ja; irq_pending = irq; mem_busy = busy;
      alu_zero = z; alu_neg = n; instr_is_load = ld; main_op = mop; func_op = fop;
      e = ref_next(model_upc, cc, ja, irq, busy, z, n, ld, mop, fop);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      model_upc = e;
   endtask

   task automatic go_to(input logic [5:0] a);
      step(4'd1, a, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h3F, 6'h3F, "R3");
   endtask

   // monitor: compares after each active edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() != 0) begin
            logic [5:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (upc !== e) begin
               n_fail++;
               $display("FAIL %s: upc=%0d expected %0d", t, upc, e);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, upc=%0d expected completion", upc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R1: counter held at zero during reset
      repeat (3) @(negedge clk);
      n_checks++;
      if (upc !== 6'd0) begin
         n_fail++;
         $display("FAIL R1: upc=%0d expected 0", upc);
      end
      rst_n = 1'b1;
      @(posedge clk); #1;
      n_checks++;
      if (upc !== 6'd0) begin
         n_fail++;
         $display("FAIL R1: upc=%0d expected 0", upc);
      end
      model_upc = 6'd0;

      // R2: sequential step and wrap
      step(4'd0, 6'd40, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'h00, 6'h00, "R2");
      go_to(6'd10);
      step(4'd0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 6'h00, "R2");
      go_to(6'd63);
      step(4'd0, 6'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 6'h00, "R2");

      // R4: each flag test, true then false
      for (int c = 2; c <= 6; c++) begin
         go_to(6'd20);
         step(4'(c), 6'd44, c == 2, c == 3, c == 4, c == 5, c == 6, 6'h00, 6'h00, "R4");
         step(4'(c), 6'd44, c != 2, c != 3, c != 4, c != 5, c != 6, 6'h00, 6'h00, "R4");
      end

      // R5: not-zero test
      go_to(6'd30);
      step(4'd10, 6'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 6'h00, "R5");
      step(4'd10, 6'd12, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'h00, 6'h00, "R5");

      // R6: reserved codes behave as sequential
      for (int c = 11; c <= 15; c++) begin
         step(4'(c), 6'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'h00, 6'h00, "R6");
         step(4'(c), 6'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 6'h00, "R6");
      end

      // R7, R11: first lookup over every main opcode
      for (int op = 0; op < 64; op++)
         step(4'd7, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'(op), 6'h3F,
              (ref_first(6'(op)) == 6'd60 && op != 6'h11) ? "R11" : "R7");

      // R8: interrupt overrides listed, unlisted and trap opcodes
      step(4'd7, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'h20, 6'h00, "R8");
      step(4'd7, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'h3F, 6'h00, "R8");
      step(4'd7, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'h11, 6'h00, "R8");
      step(4'd7, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'h04, 6'h00, "R8");

      // R9, R11: second lookup over every function opcode
      for (int op = 0; op < 64; op++)
         step(4'd8, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 6'(op),
              (ref_func(6'(op)) == 6'd60) ? "R11" : "R9");

      // R10, R11: third lookup over every main opcode
      for (int op = 0; op < 64; op++)
         step(4'd9, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'(op), 6'h00,
              (ref_third(6'(op)) == 6'd60) ? "R11" : "R10");

      // R13: second and third lookups ignore a pending interrupt
      step(4'd8, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 6'h22, "R13");
      step(4'd9, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'h08, 6'h00, "R13");
      step(4'd9, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'h3E, 6'h00, "R13");

      // R12: memory wait stalls in place, then steps once
      go_to(6'd1);
      for (int k = 0; k < 4; k++)
         step(4'd3, 6'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'h00, 6'h00, "R12");
      step(4'd3, 6'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 6'h00, "R12");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL drain: %0d results pending, expected 0", exp_q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule